// File: doc/BRIEF.md
# Boot Image Address Interleaver

This block sits between a CPU-facing access port and the buffer SRAM of a flash controller. It translates byte addresses for reads and writes alike. While the interleave mode input is high, a gap-free logical window of 3984 bytes is spread across four stored pages. Each page holds 996 user bytes and then 60 ECC bytes, so a physical page occupies 1056 bytes. The mapping skips every ECC gap, and boot code can therefore be fetched as one contiguous image.

Once the image has been consumed, software lowers the mode input. From then on, addresses go to the SRAM unchanged. Each accepted access appears at the output after exactly one clock. The mode value sampled together with the access decides how that access is translated.

Top module: `boot_addr_interleave`

## Requirements
- R1: After reset, `phys_valid` and `out_of_range` are 0.
- R2: Each output lags its accepted input by exactly one clock. An input with `log_valid`=1 at edge k produces its result in the cycle after edge k, and an idle cycle brings `phys_valid`=0 and `out_of_range`=0.
- R3: With `interleave_en`=1 and an address A < 996, the output is `phys_addr` = A.
- R4: With `interleave_en`=1 and an address A in 996..3983, page p = floor(A/996) is taken from the thresholds 996, 1992 and 2988. The output is `phys_addr` = p*1056 + (A - p*996).
- R5: With `interleave_en`=1 and A >= 3984, the output has `out_of_range`=1, `phys_valid`=0, and `phys_addr` is held at its previous value.
- R6: With `interleave_en`=0, `phys_addr` = A for any A, `phys_valid`=1 and `out_of_range`=0.
- R7: The mode is taken from the same cycle as the access. A mode change alters only accesses accepted after it.
- R8: `phys_valid` and `out_of_range` are never both 1.
- R9: The translation depends only on the address and the mode, so reads and writes map the same way. `rd_wr` passes through with the same one-clock latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| log_valid | input | 1 | Access request strobe |
| log_addr | input | ADDR_W | Logical byte address |
| rd_wr | input | 1 | 1 = write, 0 = read |
| interleave_en | input | 1 | Interleave mode enable |
| phys_valid | output | 1 | SRAM access strobe |
| phys_addr | output | ADDR_W | Physical SRAM byte address |
| phys_wr | output | 1 | Registered write qualifier |
| out_of_range | output | 1 | Access fell outside the boot window |

## Verification
All results are registered, so every result of an access is due one clock after the edge at which the access was sampled. The bench drives the stimulus on the falling edge of the clock. It waits one rising edge and then samples at the next falling edge. Idle cycles are checked the same way, to show that the strobes drop after one clock.

// File: rtl/boot_addr_interleave.sv
module boot_addr_interleave #(
  parameter int ADDR_W   = 16,
  parameter int USER_B   = 996,
  parameter int PAGE_B   = 1056,
  parameter int N_PAGES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              log_valid,
  input  logic [ADDR_W-1:0] log_addr,
  input  logic              rd_wr,
  input  logic              interleave_en,
  output logic              phys_valid,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              phys_wr,
  output logic              out_of_range
);
  localparam int WIN_B = USER_B * N_PAGES;
  localparam int GAP_B = PAGE_B - USER_B;

  logic [ADDR_W-1:0] skip;
  logic              beyond;

  always_comb begin
    skip = '0;
    for (int p = 1; p < N_PAGES; p++)
      if (32'(log_addr) >= 32'(p * USER_B)) skip = ADDR_W'(p * GAP_B);
  end

  assign beyond = interleave_en && (32'(log_addr) >= 32'(WIN_B));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phys_valid   <= 1'b0;
      out_of_range <= 1'b0;
      phys_addr    <= '0;
      phys_wr      <= 1'b0;
    end else begin
      phys_valid   <= log_valid && !beyond;
      out_of_range <= log_valid && beyond;
      if (log_valid && !beyond) begin
        phys_addr <= interleave_en ? log_addr + skip : log_addr;
        phys_wr   <= rd_wr;
      end
    end
  end
endmodule

module boot_addr_interleave_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              log_valid,
  input logic [ADDR_W-1:0] log_addr,
  input logic              interleave_en,
  input logic              phys_valid,
  input logic [ADDR_W-1:0] phys_addr,
  input logic              out_of_range
);
  // R8
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(phys_valid && out_of_range));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !log_valid |=> !phys_valid && !out_of_range);
  // R6
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid && !interleave_en |=> phys_valid && !out_of_range && phys_addr == $past(log_addr));
  // R5
  oor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_range |-> $stable(phys_addr));
  // R3
  first_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid && interleave_en && log_addr < ADDR_W'(996) |=> phys_addr == $past(log_addr));
endmodule

bind boot_addr_interleave boot_addr_interleave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .log_valid(log_valid), .log_addr(log_addr),
  .interleave_en(interleave_en), .phys_valid(phys_valid),
  .phys_addr(phys_addr), .out_of_range(out_of_range));

// File: tb/test_boot_addr_interleave.sv
module test_boot_addr_interleave;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 0, rst_n = 0, log_valid = 0, rd_wr = 0, interleave_en = 0;
  logic [AW-1:0] log_addr = '0;
  logic phys_valid, phys_wr, out_of_range;
  logic [AW-1:0] phys_addr;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_addr_interleave #(.ADDR_W(AW)) i_boot_addr_interleave (
    .clk(clk), .rst_n(rst_n), .log_valid(log_valid), .log_addr(log_addr),
    .rd_wr(rd_wr), .interleave_en(interleave_en), .phys_valid(phys_valid),
    .phys_addr(phys_addr), .phys_wr(phys_wr), .out_of_range(out_of_range));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_map(int a);
    int p = (a >= 2988) ? 3 : (a >= 1992) ? 2 : (a >= 996) ? 1 : 0;
    return p * 1056 + (a - p * 996);
  endfunction

  task automatic access(int a, bit mode, bit wr);
    @(negedge clk);
    log_valid = 1; log_addr = AW'(a); interleave_en = mode; rd_wr = wr;
    @(negedge clk);
    log_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 valid", phys_valid, 0);
    chk("R1 oor", out_of_range, 0);
  endtask

  task automatic t_low_page;
    access(0, 1, 0);   chk("R3 addr0", phys_addr, 0);
    access(995, 1, 0); chk("R3 addr995", phys_addr, 995);
    chk("R3 valid", phys_valid, 1);
  endtask

  task automatic t_upper_pages;
    int v[8] = '{996, 1500, 1991, 1992, 2987, 2988, 3500, 3983};
    foreach (v[i]) begin
      access(v[i], 1, 0);
      chk("R4 addr", phys_addr, ref_map(v[i]));
      chk("R4 valid", phys_valid, 1);
    end
  endtask

  task automatic t_oor;
    int prev;
    access(3983, 1, 0); prev = phys_addr;
    access(3984, 1, 0);
    chk("R5 oor", out_of_range, 1);
    chk("R5 valid", phys_valid, 0);
    chk("R5 hold", phys_addr, prev);
    access(60000, 1, 0);
    chk("R5 far oor", out_of_range, 1);
  endtask

  task automatic t_pass;
    int v[4] = '{0, 996, 3984, 60000};
    foreach (v[i]) begin
      access(v[i], 0, 0);
      chk("R6 addr", phys_addr, v[i]);
      chk("R6 oor", out_of_range, 0);
      chk("R6 valid", phys_valid, 1);
    end
  endtask

  task automatic t_latency;
    @(negedge clk);
    log_valid = 1; log_addr = AW'(1000); interleave_en = 1;
    @(posedge clk); #1;
    chk("R2 one-clock", phys_addr, ref_map(1000));
    @(negedge clk); log_valid = 0;
    @(negedge clk);
    chk("R2 idle valid", phys_valid, 0);
    chk("R2 idle oor", out_of_range, 0);
  endtask

  task automatic t_mode_switch;
    @(negedge clk);
    log_valid = 1; log_addr = AW'(2000); interleave_en = 1;
    @(negedge clk);
    chk("R7 on", phys_addr, ref_map(2000));
    interleave_en = 0;
    @(negedge clk);
    chk("R7 off", phys_addr, 2000);
    log_valid = 0;
  endtask

  task automatic t_rw;
    access(3000, 1, 1);
    chk("R9 write addr", phys_addr, ref_map(3000));
    chk("R9 write flag", phys_wr, 1);
    access(3000, 1, 0);
    chk("R9 read addr", phys_addr, ref_map(3000));
    chk("R9 read flag", phys_wr, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    t_reset;
    rst_n = 1;
    t_low_page; t_upper_pages; t_oor; t_pass; t_latency; t_mode_switch; t_rw;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule